// File: doc/BRIEF.md
# Saturating Signed Sample Accumulator

This block keeps a wide signed running total of narrow input samples. On each cycle where a sample is offered, the sample is widened to the accumulator width and added to the total. A per-sample mode input says how to read the sample. When the sample is signed, its top bit is replicated into the upper bits. When it is unsigned, the upper bits are filled with zeros.

The block decides overflow from the two's-complement sign rule and never from the adder's carry. Overflow happens when the total and the widened sample have the same sign and the new total has the opposite sign. With saturation enabled, an overflowing add sets the total to the largest or smallest signed value, on the side of the operands' sign. With saturation disabled, the total wraps. In both modes a sticky flag records that some information was lost. A typical use is summing a stream of converter samples or filter taps, where a clamped total is worse than an exact one but far better than a sign flip.

Top module: `sacc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block loads `acc_out` = 0, `ovf_sticky` = 0 and `sat_flag` = 0, visible after that edge.
- R2: `clr` = 1 at an edge has the same effect as reset and takes priority over `smp_vld`.
- R3: With `clr` = 0 and `smp_vld` = 0, `acc_out`, `ovf_sticky` and `sat_flag` keep their values, whatever `smp_data`, `smp_signed` and `sat_en` are.
- R4: With `smp_signed` = 1, the sample is treated as two's complement: bit SAMPLE_W-1 is copied into every upper bit before the add, so 0xFFF adds -1 at SAMPLE_W = 12.
- R5: With `smp_signed` = 0, the sample is zero-extended, so 0xFFF adds +4095 at SAMPLE_W = 12.
- R6: Overflow is raised only when the total and the widened sample share a sign bit and the new total's sign bit differs from it. The unsigned carry plays no part: a total of -1 plus a sample of +1 gives 0 with no flag.
- R7: With `sat_en` = 1, a positive overflow loads the signed maximum: a 0 followed by ACC_W-1 ones.
- R8: With `sat_en` = 1, a negative overflow loads the signed minimum: a 1 followed by ACC_W-1 zeros.
- R9: With `sat_en` = 0, an overflowing add wraps modulo 2^ACC_W. Adding a zero sample leaves the total unchanged.
- R10: `ovf_sticky` rises on the edge that accepts any overflowing add, in either saturation mode. It then stays at 1 until reset or clear.
- R11: After a clamp, later samples are added normally to the clamped value.
- R12: `sat_flag` is 1 exactly when the most recently accepted add was clamped, which requires `sat_en` = 1 together with an overflow. An accepted add that does not clamp drops it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of total and flags |
| smp_vld | input | 1 | Sample present this cycle |
| smp_data | input | SAMPLE_W | Sample bits |
| smp_signed | input | 1 | 1: sample is two's complement; 0: sample is unsigned |
| sat_en | input | 1 | 1: clamp on overflow; 0: wrap |
| acc_out | output | ACC_W | Running total, two's complement |
| ovf_sticky | output | 1 | Some accepted add overflowed since the last reset or clear |
| sat_flag | output | 1 | The last accepted add was clamped |

## Verification
The total is held in a single register and has no hidden pipeline state. A wrong extension, a wrong overflow decision or a wrong clamp value therefore appears on `acc_out` on the edge right after the offending sample. Because the error is never flushed, it stays there and shifts every later total. Flag errors also show up on the next edge, and a stuck or dropped sticky bit stays visible until the next clear. The bench compares all three outputs with a behavioural integer model on every cycle, so a fault is reported on the first cycle it appears. The stimulus aims at the cases where carry and sign overflow disagree, at exact landings on the limits, and at recovery from a clamp.

// File: rtl/sacc_pkg.sv
// Package: shared types for the saturating accumulator.
// Assumes nothing beyond being compiled before the modules that import it.
package sacc_pkg;

    // Outcome of one add, judged on the two's-complement sign rule.
    typedef enum logic [1:0] {
        OVF_NONE = 2'b00,
        OVF_POS  = 2'b01,
        OVF_NEG  = 2'b10
    } ovf_kind_t;

endpackage

// File: rtl/sacc_extend.sv
// Module: sacc_extend
// Widens a SAMPLE_W-bit sample to ACC_W bits. Sign extension is used when
// is_signed is 1 and zero extension when it is 0.
// Assumes ACC_W >= SAMPLE_W.
module sacc_extend #(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 32
) (
    input  logic [SAMPLE_W-1:0] din,
    input  logic                is_signed,
    output logic [ACC_W-1:0]    dout
);
    localparam int PAD_W = ACC_W - SAMPLE_W;

    generate
        if (PAD_W > 0) begin : g_pad
            logic fill_bit;
            // Fill bit: the sample's top bit for signed data, else zero.
            always_comb fill_bit = is_signed & din[SAMPLE_W-1];
            // Replicate the fill bit above the sample.
            always_comb dout = {{PAD_W{fill_bit}}, din};
        end else begin : g_same
            logic unused_mode;
            // Equal widths: nothing to widen; the mode has no effect.
            always_comb unused_mode = is_signed;
            always_comb dout = din;
        end
    endgenerate

endmodule

// File: rtl/sacc_addv.sv
// Module: sacc_addv
// Adds two ACC_W-bit two's-complement words modulo 2^ACC_W and reports
// signed overflow from the sign bits only. The carry out of the top bit
// is never formed.
// Assumes ACC_W >= 2.
module sacc_addv
    import sacc_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] lhs,
    input  logic [ACC_W-1:0] rhs,
    output logic [ACC_W-1:0] sum,
    output ovf_kind_t        kind
);
    localparam int MSB = ACC_W - 1;

    logic same_sign;
    logic sign_flip;

    // Modular sum; the result width drops the carry.
    always_comb sum = lhs + rhs;

    // Sign rule: same-signed operands giving an opposite-signed result.
    always_comb begin
        same_sign = (lhs[MSB] == rhs[MSB]);
        sign_flip = (sum[MSB] != lhs[MSB]);
    end

    // Classify the overflow direction by the operands' common sign.
    always_comb begin
        if (same_sign && sign_flip)
            kind = lhs[MSB] ? OVF_NEG : OVF_POS;
        else
            kind = OVF_NONE;
    end

endmodule

// File: rtl/sacc_clamp.sv
// Module: sacc_clamp
// Picks the next total. With sat_en set, an overflowing sum is replaced by
// the signed limit on the operands' side. Otherwise the wrapped sum is
// passed through.
// Assumes kind comes from the same add that produced sum.
module sacc_clamp
    import sacc_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] sum,
    input  ovf_kind_t        kind,
    input  logic             sat_en,
    output logic [ACC_W-1:0] nxt,
    output logic             clamped
);
    localparam logic [ACC_W-1:0] LIM_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] LIM_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // Select the limit or the raw sum.
    always_comb begin
        nxt     = sum;
        clamped = 1'b0;
        if (sat_en) begin
            unique case (kind)
                OVF_POS: begin nxt = LIM_MAX; clamped = 1'b1; end
                OVF_NEG: begin nxt = LIM_MIN; clamped = 1'b1; end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sacc_top.sv
// Module: sacc_top
// Saturating signed sample accumulator. Each valid sample is widened,
// added to the registered total and checked for signed overflow. The
// total then either clamps or wraps according to sat_en.
// Assumes ACC_W > SAMPLE_W for a useful headroom, and a synchronous,
// active-low reset.
module sacc_top
    import sacc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_signed,
    input  logic                sat_en,
    output logic [ACC_W-1:0]    acc_out,
    output logic                ovf_sticky,
    output logic                sat_flag
);
    logic [ACC_W-1:0] smp_wide;
    logic [ACC_W-1:0] raw_sum;
    logic [ACC_W-1:0] next_total;
    ovf_kind_t        add_kind;
    logic             add_clamped;
    logic             add_ovf;

    sacc_extend #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_ext (
        .din       (smp_data),
        .is_signed (smp_signed),
        .dout      (smp_wide)
    );

    sacc_addv #(.ACC_W(ACC_W)) u_add (
        .lhs  (acc_out),
        .rhs  (smp_wide),
        .sum  (raw_sum),
        .kind (add_kind)
    );

    sacc_clamp #(.ACC_W(ACC_W)) u_clamp (
        .sum     (raw_sum),
        .kind    (add_kind),
        .sat_en  (sat_en),
        .nxt     (next_total),
        .clamped (add_clamped)
    );

    // Any overflow direction counts toward the sticky record.
    always_comb add_ovf = (add_kind != OVF_NONE);

    // Total and flag registers: reset/clear first, then accept a sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_out    <= '0;
            ovf_sticky <= 1'b0;
            sat_flag   <= 1'b0;
        end else if (smp_vld) begin
            acc_out    <= next_total;
            ovf_sticky <= ovf_sticky | add_ovf;
            sat_flag   <= add_clamped;
        end
    end

endmodule

// File: rtl/sacc_checker.sv
// Module: sacc_checker
// Port-level temporal checks for sacc_top, attached with bind below.
// Assumes the same parameters as the bound instance.
module sacc_checker #(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                smp_vld,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                smp_signed,
    input logic                sat_en,
    input logic [ACC_W-1:0]    acc_out,
    input logic                ovf_sticky,
    input logic                sat_flag
);
    logic smp_neg;
    logic take;

    // Sign of the widened sample, derived from the mode and the top bit.
    always_comb smp_neg = smp_signed & smp_data[SAMPLE_W-1];
    // An add is accepted this cycle.
    always_comb take = smp_vld & ~clr;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && !ovf_sticky && !sat_flag));

    a_r2_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0 && !ovf_sticky && !sat_flag));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !smp_vld) |=> ($stable(acc_out) && $stable(ovf_sticky) && $stable(sat_flag)));

    a_r7_no_pos_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sat_en && !acc_out[ACC_W-1] && !smp_neg) |=> !acc_out[ACC_W-1]);

    a_r8_no_neg_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sat_en && acc_out[ACC_W-1] && smp_neg) |=> acc_out[ACC_W-1]);

    a_r9_zero_add: assert property (@(posedge clk) disable iff (!rst_n)
        (take && smp_data == '0) |=> ($stable(acc_out) && !sat_flag));

    a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !clr) |=> ovf_sticky);

    a_r12_sat_implies_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> ovf_sticky);

endmodule

bind sacc_top sacc_checker #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .smp_signed (smp_signed),
    .sat_en     (sat_en),
    .acc_out    (acc_out),
    .ovf_sticky (ovf_sticky),
    .sat_flag   (sat_flag)
);

// File: tb/sim_sacc_top.sv
// Bench for sacc_top: drives inputs on the falling edge, advances an
// integer reference model on each rising edge and compares all outputs
// one falling edge later.
module sim_sacc_top;
    localparam int SW = 12;
    localparam int AW = 16;
    localparam longint MAXV = (longint'(1) <<< (AW - 1)) - 1;
    localparam longint MINV = -MAXV - 1;
    localparam longint SPAN = longint'(1) <<< AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          smp_vld = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          smp_signed = 1'b0;
    logic          sat_en = 1'b0;
    logic [AW-1:0] acc_out;
    logic          ovf_sticky;
    logic          sat_flag;

    int     n_tests = 0;
    int     n_fail = 0;
    longint m_acc = 0;
    logic   m_ovf = 1'b0;
    logic   m_sat = 1'b0;

    always #5 clk = ~clk;

    sacc_top #(.SAMPLE_W(SW), .ACC_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .smp_data(smp_data), .smp_signed(smp_signed), .sat_en(sat_en),
        .acc_out(acc_out), .ovf_sticky(ovf_sticky), .sat_flag(sat_flag)
    );

    task automatic compare(input string tag);
        longint got;
        got = longint'($signed(acc_out));
        n_tests++;
        if (got != m_acc || ovf_sticky !== m_ovf || sat_flag !== m_sat) begin
            n_fail++;
            $display("FAIL %s: acc=%0d ovf=%b sat=%b, expected acc=%0d ovf=%b sat=%b",
                     tag, got, ovf_sticky, sat_flag, m_acc, m_ovf, m_sat);
        end
    endtask

    task automatic model_add(input logic [SW-1:0] d, input logic sg, input logic st);
        longint sv;
        longint t;
        sv = sg ? longint'($signed(d)) : longint'(d);
        t  = m_acc + sv;
        if (t > MAXV || t < MINV) begin
            m_ovf = 1'b1;
            if (st) begin
                m_acc = (t > MAXV) ? MAXV : MINV;
                m_sat = 1'b1;
            end else begin
                m_acc = (t > MAXV) ? t - SPAN : t + SPAN;
                m_sat = 1'b0;
            end
        end else begin
            m_acc = t;
            m_sat = 1'b0;
        end
    endtask

    task automatic step(input logic v, input logic [SW-1:0] d, input logic sg,
                        input logic st, input logic c, input string tag);
        smp_vld = v; smp_data = d; smp_signed = sg; sat_en = st; clr = c;
        @(posedge clk);
        if (c) begin
            m_acc = 0; m_ovf = 1'b0; m_sat = 1'b0;
        end else if (v) begin
            model_add(d, sg, st);
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0; smp_vld = 1'b1; smp_data = 12'h123;
        @(posedge clk);
        m_acc = 0; m_ovf = 1'b0; m_sat = 1'b0;
        @(negedge clk);
        compare(tag);
        rst_n = 1'b1; smp_vld = 1'b0;
    endtask

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1 reset");
        do_reset("R1 reset");

        // R4: signed samples, both signs
        step(1, 12'h005, 1, 0, 0, "R4 signed +5");
        step(1, 12'hFFD, 1, 0, 0, "R4 signed -3");
        step(1, 12'h800, 1, 0, 0, "R4 signed -2048");
        // R5: unsigned samples with top bit set
        step(1, 12'hFFF, 0, 0, 0, "R5 unsigned 4095");
        step(1, 12'h800, 0, 0, 0, "R5 unsigned 2048");
        // R3: idle cycles with busy inputs
        for (int i = 0; i < 3; i++) step(0, 12'h7FF, i[0], 1, 0, "R3 hold");
        // R2: clear beats a valid sample
        step(1, 12'h7FF, 1, 0, 1, "R2 clear priority");
        // R6: -1 + 1 gives 0 with no overflow
        step(1, 12'hFFF, 1, 1, 0, "R6 load -1");
        step(1, 12'h001, 1, 1, 0, "R6 -1 plus 1");
        // R7: positive clamp, then R11 recovery
        for (int i = 0; i < 9; i++) step(1, 12'hFFF, 0, 1, 0, "R7 climb to MAX");
        step(0, 12'h000, 0, 1, 0, "R10 sticky held");
        step(1, 12'hFFF, 1, 1, 0, "R11 add -1 after clamp");
        step(1, 12'h002, 0, 1, 0, "R7 clamp again");
        step(1, 12'h000, 1, 1, 0, "R12 flag drops on normal add");
        step(1, 12'h000, 1, 0, 1, "R10 cleared by clear");
        // R8: exact landing on MIN, then negative clamp
        for (int i = 0; i < 16; i++) step(1, 12'h800, 1, 1, 0, "R8 descend to MIN");
        step(1, 12'h800, 1, 1, 0, "R8 clamp at MIN");
        step(1, 12'h7FF, 1, 1, 0, "R11 add after MIN clamp");
        // R9: wrap mode
        step(0, 12'h000, 0, 0, 1, "R2 clear");
        for (int i = 0; i < 9; i++) step(1, 12'hFFF, 0, 0, 0, "R9 wrap climb");
        for (int i = 0; i < 20; i++) step(1, 12'h800, 1, 0, 0, "R9 wrap descend");
        step(1, 12'h000, 0, 0, 0, "R9 zero add");
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[31] | r[30], r[SW-1:0], r[20], r[21], (r[29:26] == 4'h0),
                 "R4 R5 R9 mixed");
        end
        do_reset("R1 mid-run reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule